// File: doc/BRIEF.md
# Tile Background Scanline Fetcher

This block builds the background layer of one display line for a tile-mapped video engine. A single-cycle start pulse latches a line number, a vertical scroll value and a name-table base register. For each visible map column it reads a packed 16-bit tile entry and then the four bitplane bytes of the selected pattern row from a video memory read port. It turns those planar bytes into 4-bit colour indices, with horizontal and vertical flip applied, and looks each index up through a palette read port. The result is a stream of 12-bit RGB pixels, each tagged with a valid strobe and the tile's priority bit. A done pulse marks the last pixel of the line.

Both memory ports are synchronous. An address presented during one cycle yields its data during the next cycle. The block holds no memory of its own. The rendered window is fixed at twenty map columns of eight pixels each, so a line has 160 pixels.

The controller is a state machine with these states. IDLE waits for start. ENT_LO issues the low entry byte address and ENT_HI the high one. ENT_CAP receives the high byte. PLANE issues the four plane addresses and collects the bytes over five cycles. PIXEL emits eight palette lookups. The transitions are: IDLE to ENT_LO on start; ENT_LO to ENT_HI to ENT_CAP to PLANE unconditionally; PLANE to PIXEL after the fifth cycle; PIXEL to ENT_LO for the next column, or PIXEL to IDLE after the last pixel of the last column.

Top module: `bg_line_fetch`

## Requirements
- R1: After reset, pix_valid, line_done, vram_re and pal_re are all low, and the block stays idle until start.
- R2: The name-table base address is base_reg bits 3:1 placed at address bits 13:11. The other bits of base_reg have no effect.
- R3: The map row is (line + vscroll) modulo 224. Entry address = base + 2 × (32 × (map row / 8) + column). Columns 6 to 25 are fetched in rising order. The low byte at the even address is read first, then the high byte at the next address.
- R4: The tile entry fields are decoded as follows: bits 8:0 pattern number, bit 9 horizontal flip, bit 10 vertical flip, bit 11 palette select, bit 12 priority. Bits 15:13 are ignored.
- R5: Plane byte k (k = 0..3) is read at pattern × 32 + 4 × r + k. Here r is the map row modulo 8, or 7 minus that value when vertical flip is set.
- R6: Pixel p of a tile (p = 0 leftmost) takes colour index bit k from bit (7 − p) of plane k. When horizontal flip is set, it uses bit p instead.
- R7: The palette word address is the colour index plus 16 when palette select is set. pix_rgb carries bits 11:0 of the returned palette word (red 3:0, green 7:4, blue 11:8).
- R8: pix_prio equals the entry priority bit for all eight pixels of that tile.
- R9: A line produces exactly 160 valid pixels, 8 consecutive per tile and 16 cycles per tile. The first pixel appears 10 clock edges after the edge that samples start. line_done pulses for one cycle together with the last pixel, 321 edges after that edge.
- R10: A start pulse while a line is in progress is ignored. The line in progress, including its latched inputs, completes unchanged, with a single line_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one line; sampled only while idle |
| line | input | 8 | Display line number, latched at start |
| vscroll | input | 8 | Vertical scroll value, latched at start |
| base_reg | input | 8 | Name-table base register, latched at start |
| vram_re | output | 1 | Video memory read strobe |
| vram_addr | output | 14 | Video memory byte address |
| vram_data | input | 8 | Byte returned one cycle after its address |
| pal_re | output | 1 | Palette read strobe |
| pal_addr | output | 5 | Palette word address |
| pal_data | input | 16 | Palette word returned one cycle after its address |
| pix_valid | output | 1 | Pixel strobe |
| pix_rgb | output | 12 | Pixel colour |
| pix_prio | output | 1 | Pixel priority from the tile entry |
| line_done | output | 1 | One-cycle end-of-line pulse |

## Verification
Counting edges from the one that samples start: the low entry address is on the port right after that edge, the high byte address one edge later, and the first plane address three edges later. Pixel n of the line is due at edge 10 + 16 × (n / 8) + (n mod 8), and line_done is due at edge 321. The bench drives inputs and samples outputs on falling edges, counting edges from start. It checks the address probes at their exact edge, checks each pixel against a model computed from hashed memory contents, and checks that the first pixel and line_done arrive on their exact edges.

// File: rtl/bgf_pkg.sv
package bgf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENT_LO,
        ST_ENT_HI,
        ST_ENT_CAP,
        ST_PLANE,
        ST_PIXEL
    } fetch_state_t;

    typedef struct packed {
        logic [2:0] spare;
        logic       prio;
        logic       pal_sel;
        logic       vflip;
        logic       hflip;
        logic [8:0] pattern;
    } tile_entry_t;

endpackage

// File: rtl/bgf_ctrl.sv
module bgf_ctrl
    import bgf_pkg::*;
#(
    parameter int COL_FIRST = 6,
    parameter int COL_LAST  = 25,
    parameter int PLANES    = 4,
    parameter int TILE_PX   = 8,
    parameter int COL_W     = $clog2(COL_LAST + 1),
    parameter int SUB_W     = $clog2(((PLANES + 1) > TILE_PX) ? (PLANES + 1) : TILE_PX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output fetch_state_t     state_o,
    output logic [COL_W-1:0] col_o,
    output logic [SUB_W-1:0] sub_o,
    output logic             last_pix_o
);

    localparam logic [COL_W-1:0] COL_A = COL_W'(COL_FIRST);
    localparam logic [COL_W-1:0] COL_Z = COL_W'(COL_LAST);
    localparam logic [SUB_W-1:0] SUB_PL = SUB_W'(PLANES);
    localparam logic [SUB_W-1:0] SUB_PX = SUB_W'(TILE_PX - 1);

    fetch_state_t     state_q, state_n;
    logic [COL_W-1:0] col_q, col_n;
    logic [SUB_W-1:0] sub_q, sub_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            col_q   <= COL_A;
            sub_q   <= '0;
        end else begin
            state_q <= state_n;
            col_q   <= col_n;
            sub_q   <= sub_n;
        end
    end

    always_comb begin
        state_n = state_q;
        col_n   = col_q;
        sub_n   = sub_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_n = ST_ENT_LO;
                    col_n   = COL_A;
                end
            end
            ST_ENT_LO:  state_n = ST_ENT_HI;
            ST_ENT_HI:  state_n = ST_ENT_CAP;
            ST_ENT_CAP: begin
                state_n = ST_PLANE;
                sub_n   = '0;
            end
            ST_PLANE: begin
                if (sub_q == SUB_PL) begin
                    state_n = ST_PIXEL;
                    sub_n   = '0;
                end else begin
                    sub_n = sub_q + 1'b1;
                end
            end
            ST_PIXEL: begin
                if (sub_q == SUB_PX) begin
                    sub_n = '0;
                    if (col_q == COL_Z) begin
                        state_n = ST_IDLE;
                    end else begin
                        col_n   = col_q + 1'b1;
                        state_n = ST_ENT_LO;
                    end
                end else begin
                    sub_n = sub_q + 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign state_o    = state_q;
    assign col_o      = col_q;
    assign sub_o      = sub_q;
    assign last_pix_o = (state_q == ST_PIXEL) && (sub_q == SUB_PX) && (col_q == COL_Z);

    // R3
    ent_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENT_LO) |=> (state_q == ST_ENT_HI));

    // R9
    line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_pix_o |=> (state_q == ST_IDLE));

    // R10
    col_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (col_q >= $past(col_q)));

endmodule

// File: rtl/bgf_addr.sv
module bgf_addr
    import bgf_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int MAP_LINES = 224,
    parameter int COL_W     = 5,
    parameter int SUB_W     = 3
) (
    input  fetch_state_t     state,
    input  logic [7:0]       line_q,
    input  logic [7:0]       vscroll_q,
    input  logic [7:0]       base_reg_q,
    input  logic [COL_W-1:0] col,
    input  logic [SUB_W-1:0] sub,
    input  tile_entry_t      entry,
    output logic [ADDR_W-1:0] vram_addr
);

    localparam logic [8:0] WRAP1 = 9'(MAP_LINES);
    localparam logic [8:0] WRAP2 = 9'(2 * MAP_LINES);

    logic [8:0]        row_sum;
    logic [8:0]        map_row;
    logic [4:0]        tile_row;
    logic [2:0]        fine_row;
    logic [2:0]        pat_row;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] ent_addr;
    logic [ADDR_W-1:0] plane_addr;

    always_comb begin
        row_sum = {1'b0, line_q} + {1'b0, vscroll_q};
        if (row_sum >= WRAP2)      map_row = row_sum - WRAP2;
        else if (row_sum >= WRAP1) map_row = row_sum - WRAP1;
        else                       map_row = row_sum;
    end

    assign tile_row   = map_row[7:3];
    assign fine_row   = map_row[2:0];
    assign pat_row    = entry.vflip ? ~fine_row : fine_row;
    assign base_addr  = {base_reg_q[3:1], {(ADDR_W-3){1'b0}}};
    assign ent_addr   = base_addr + ADDR_W'({tile_row, col, 1'b0});
    assign plane_addr = {entry.pattern, pat_row, sub[1:0]};

    always_comb begin
        unique case (state)
            ST_ENT_LO: vram_addr = ent_addr;
            ST_ENT_HI: vram_addr = {ent_addr[ADDR_W-1:1], 1'b1};
            ST_PLANE:  vram_addr = plane_addr;
            default:   vram_addr = '0;
        endcase
    end

endmodule

// File: rtl/bgf_pixsel.sv
module bgf_pixsel
    import bgf_pkg::*;
#(
    parameter int PLANES = 4,
    parameter int SUB_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fetch_state_t      state,
    input  logic [SUB_W-1:0]  sub,
    input  logic [7:0]        vram_data,
    output tile_entry_t       entry_o,
    output logic [PLANES:0]   pal_addr
);

    tile_entry_t       entry_q;
    logic [7:0]        plane_q [PLANES];
    logic [2:0]        px_bit;
    logic [PLANES-1:0] color_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q <= '0;
            for (int k = 0; k < PLANES; k++) plane_q[k] <= '0;
        end else begin
            if (state == ST_ENT_HI)  entry_q[7:0]  <= vram_data;
            if (state == ST_ENT_CAP) entry_q[15:8] <= vram_data;
            if (state == ST_PLANE) begin
                for (int k = 0; k < PLANES; k++) begin
                    if (sub == SUB_W'(k + 1)) plane_q[k] <= vram_data;
                end
            end
        end
    end

    assign px_bit = entry_q.hflip ? sub[2:0] : ~sub[2:0];

    for (genvar k = 0; k < PLANES; k++) begin : g_idx
        assign color_idx[k] = plane_q[k][px_bit];
    end

    assign pal_addr = {entry_q.pal_sel, color_idx};
    assign entry_o  = entry_q;

    // R8
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PIXEL) |-> $stable(entry_q));

endmodule

// File: rtl/bg_line_fetch.sv
module bg_line_fetch
    import bgf_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int MAP_LINES = 224,
    parameter int COL_FIRST = 6,
    parameter int COL_LAST  = 25,
    parameter int PLANES    = 4,
    parameter int TILE_PX   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        line,
    input  logic [7:0]        vscroll,
    input  logic [7:0]        base_reg,
    output logic              vram_re,
    output logic [ADDR_W-1:0] vram_addr,
    input  logic [7:0]        vram_data,
    output logic              pal_re,
    output logic [PLANES:0]   pal_addr,
    input  logic [15:0]       pal_data,
    output logic              pix_valid,
    output logic [11:0]       pix_rgb,
    output logic              pix_prio,
    output logic              line_done
);

    localparam int COL_W = $clog2(COL_LAST + 1);
    localparam int SUB_W = $clog2(((PLANES + 1) > TILE_PX) ? (PLANES + 1) : TILE_PX);

    fetch_state_t     state;
    logic [COL_W-1:0] col;
    logic [SUB_W-1:0] sub;
    logic             last_pix;
    tile_entry_t      entry;
    logic [7:0]       line_q, vscroll_q, base_q;
    logic             valid_q, prio_q, done_q;

    bgf_ctrl #(
        .COL_FIRST(COL_FIRST), .COL_LAST(COL_LAST), .PLANES(PLANES),
        .TILE_PX(TILE_PX), .COL_W(COL_W), .SUB_W(SUB_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .state_o(state), .col_o(col), .sub_o(sub), .last_pix_o(last_pix)
    );

    bgf_addr #(
        .ADDR_W(ADDR_W), .MAP_LINES(MAP_LINES), .COL_W(COL_W), .SUB_W(SUB_W)
    ) u_addr (
        .state(state), .line_q(line_q), .vscroll_q(vscroll_q),
        .base_reg_q(base_q), .col(col), .sub(sub), .entry(entry),
        .vram_addr(vram_addr)
    );

    bgf_pixsel #(
        .PLANES(PLANES), .SUB_W(SUB_W)
    ) u_pix (
        .clk(clk), .rst_n(rst_n), .state(state), .sub(sub),
        .vram_data(vram_data), .entry_o(entry), .pal_addr(pal_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q    <= '0;
            vscroll_q <= '0;
            base_q    <= '0;
            valid_q   <= 1'b0;
            prio_q    <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                line_q    <= line;
                vscroll_q <= vscroll;
                base_q    <= base_reg;
            end
            valid_q <= (state == ST_PIXEL);
            prio_q  <= entry.prio;
            done_q  <= last_pix;
        end
    end

    always_comb begin
        vram_re = (state == ST_ENT_LO) || (state == ST_ENT_HI) ||
                  ((state == ST_PLANE) && (sub < SUB_W'(PLANES)));
        pal_re  = (state == ST_PIXEL);
    end

    assign pix_valid = valid_q;
    assign pix_rgb   = valid_q ? pal_data[11:0] : 12'h000;
    assign pix_prio  = valid_q & prio_q;
    assign line_done = done_q;

    // R9
    done_with_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> pix_valid);

    // R7
    valid_after_pal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(pal_re));

    // R3
    hi_byte_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENT_HI) |-> (vram_addr == ADDR_W'($past(vram_addr) + 1'b1)));

endmodule

// File: tb/bg_line_fetch_test.sv
module bg_line_fetch_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  line = '0, vscroll = '0, base_reg = '0;
    logic        vram_re, pal_re, pix_valid, pix_prio, line_done;
    logic [13:0] vram_addr;
    logic [7:0]  vram_data = '0;
    logic [4:0]  pal_addr;
    logic [15:0] pal_data = '0;
    logic [11:0] pix_rgb;

    int checks = 0;
    int fails = 0;
    int unsigned seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    bg_line_fetch uut (
        .clk(clk), .rst_n(rst_n), .start(start), .line(line),
        .vscroll(vscroll), .base_reg(base_reg), .vram_re(vram_re),
        .vram_addr(vram_addr), .vram_data(vram_data), .pal_re(pal_re),
        .pal_addr(pal_addr), .pal_data(pal_data), .pix_valid(pix_valid),
        .pix_rgb(pix_rgb), .pix_prio(pix_prio), .line_done(line_done)
    );

    function automatic logic [7:0] vmem(input logic [13:0] a);
        logic [31:0] h;
        h = ({18'b0, a} * 32'h9E37_79B1) ^ seed;
        h = h ^ (h >> 15);
        return h[7:0] ^ h[23:16];
    endfunction

    function automatic logic [15:0] pmem(input logic [4:0] a);
        logic [31:0] h;
        h = ({27'b0, a} * 32'h85EB_CA6B) ^ (seed * 7);
        h = h ^ (h >> 13);
        return h[15:0];
    endfunction

    always @(posedge clk) begin
        vram_data <= vmem(vram_addr);
        pal_data  <= pmem(pal_addr);
    end

    function automatic int f_row(input int ln, input int vs);
        return (ln + vs) % 224;
    endfunction

    function automatic logic [13:0] f_ent(input int ln, input int vs, input int rg, input int col);
        return 14'(((rg & 'hE) << 10) + ((f_row(ln, vs) / 8) * 32 + col) * 2);
    endfunction

    function automatic logic [15:0] f_word(input int ln, input int vs, input int rg, input int col);
        logic [13:0] a;
        a = f_ent(ln, vs, rg, col);
        return {vmem(14'(a + 1)), vmem(a)};
    endfunction

    function automatic logic [13:0] f_plane(input int ln, input int vs, input int rg, input int col, input int k);
        logic [15:0] w;
        int fine;
        w = f_word(ln, vs, rg, col);
        fine = f_row(ln, vs) % 8;
        if (w[10]) fine = 7 - fine;
        return 14'(int'(w[8:0]) * 32 + 4 * fine + k);
    endfunction

    function automatic logic [12:0] exp_pix(input int ln, input int vs, input int rg, input int n);
        logic [15:0] w;
        logic [7:0]  pb;
        logic [3:0]  idx;
        int col, p, b;
        col = 6 + n / 8;
        p = n % 8;
        w = f_word(ln, vs, rg, col);
        b = w[9] ? p : 7 - p;
        for (int k = 0; k < 4; k++) begin
            pb = vmem(f_plane(ln, vs, rg, col, k));
            idx[k] = pb[b];
        end
        return {w[12], pmem({w[11], idx})[11:0]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_line(input int ln, input int vs, input int rg, input bit busy_start);
        int npix, ndone, first_j, done_j;
        logic [12:0] e;
        npix = 0; ndone = 0; first_j = -1; done_j = -1;
        @(negedge clk);
        line = 8'(ln); vscroll = 8'(vs); base_reg = 8'(rg); start = 1'b1;
        @(posedge clk);
        for (int j = 0; j < 335; j++) begin
            @(negedge clk);
            if (j == 0) begin
                start = 1'b0;
                // R2 R3: first entry low byte address
                check(vram_addr == f_ent(ln, vs, rg, 6) && vram_re, "R2/R3 entry addr",
                      vram_addr, f_ent(ln, vs, rg, 6));
            end
            if (j == 1)  // R3: high byte next
                check(vram_addr == 14'(f_ent(ln, vs, rg, 6) + 1), "R3 high byte addr",
                      vram_addr, 14'(f_ent(ln, vs, rg, 6) + 1));
            if (j == 3)  // R5: plane 0 address
                check(vram_addr == f_plane(ln, vs, rg, 6, 0), "R5 plane addr",
                      vram_addr, f_plane(ln, vs, rg, 6, 0));
            if (busy_start && j == 50) begin
                start = 1'b1; line = 8'(ln + 77); vscroll = 8'(vs + 33); base_reg = 8'(rg ^ 8'h0E);
            end
            if (busy_start && j == 51) start = 1'b0;
            if (pix_valid) begin
                if (first_j < 0) first_j = j;
                if (npix < 160) begin
                    e = exp_pix(ln, vs, rg, npix);
                    check(pix_rgb == e[11:0], "R4/R6/R7 pixel colour", pix_rgb, e[11:0]);
                    check(pix_prio == e[12], "R8 priority", pix_prio, e[12]);
                end
                npix++;
            end
            if (line_done) begin
                ndone++;
                done_j = j;
            end
        end
        check(npix == 160, "R9 pixel count", npix, 160);
        check(first_j == 9, "R9 first pixel edge", first_j + 1, 10);
        check(done_j == 320, "R9 done edge", done_j + 1, 321);
        check(ndone == 1, busy_start ? "R10 single done" : "R9 single done", ndone, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!pix_valid && !line_done && !vram_re && !pal_re, "R1 reset outputs",
              {pix_valid, line_done, vram_re, pal_re}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!pix_valid && !vram_re && !pal_re, "R1 idle without start",
              {pix_valid, vram_re, pal_re}, 0);

        run_line(0, 0, 8'h00, 1'b0);
        seed = 32'hA5A5_0F0F;
        run_line(200, 100, 8'hFF, 1'b0);   // wrap past 224
        seed = 32'h0BAD_F00D;
        run_line(255, 255, 8'hF1, 1'b0);   // double wrap, R2 ignored bits
        seed = 32'h7777_1111;
        run_line(223, 0, 8'h0E, 1'b0);
        seed = 32'h3141_5926;
        run_line(40, 9, 8'h06, 1'b1);      // R10 busy start
        for (int i = 0; i < 6; i++) begin
            seed = $urandom(100 + i);
            run_line(int'($urandom % 256), int'($urandom % 256), int'($urandom % 256), i[0]);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule